// File: doc/BRIEF.md
# I2C Mode-Control Register

This block is one control register of an I2C controller. It holds three writable bits: the master-mode bit, the transmit-direction bit and the acknowledge-check enable. It also holds one read-only flag that records a not-acknowledge. Software reaches the register through a simple single-cycle port that has a select, a write strobe and a read strobe. The bus engine next to this block drives single-cycle strobes for three hardware events: lost arbitration, a slave address match together with the received R/W bit, and the sampling of the acknowledge bit.

Hardware events take priority over software. A bit that hardware has changed becomes locked. Software can undo that change only after it has read the register while the bit holds its new value. This prevents a stale read-modify-write from silently cancelling an arbitration loss or a slave-transmit request. When acknowledge checking is enabled and a received acknowledge bit is 1, the block raises a one-cycle halt request for the transfer engine.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset, `is_master`, `is_tx`, `ack_flag` and `halt_req` are 0, and a register read returns 0x00.
- R2: Field positions are: master at bit 5, transmit at bit 4, acknowledge-check enable at bit 3, and the read-only not-acknowledge flag at bit 1. All other bits read 0. Writes and reads take effect only while `reg_sel` is 1, and `reg_rdata` is 0 when no read is selected.
- R3: A pulse on `arb_lost` while `is_master` is 1 clears both master and transmit at the next edge. While `is_master` is 0, `arb_lost` has no effect.
- R4: After an arbitration-loss clear, a write of 1 to master is ignored until a register read has returned master as 0. The first write of 1 after that read sets the bit, and the bit behaves as a plain register again.
- R5: `slv_match` with `rx_rw`=1 while `is_master` is 0 sets transmit at the next edge. With `rx_rw`=0, or while `is_master` is 1, transmit is unchanged.
- R6: After transmit has been set by a slave match, a write of 0 to it is ignored until a read has returned it as 1. The next write of 0 then clears it, and later writes act plainly.
- R7: After an arbitration-loss clear of transmit, a write of 1 to it is ignored until a read has returned it as 0.
- R8: When a hardware event and a software write hit the same bit in the same cycle, the hardware value is stored. The bit becomes locked again, and any earlier read permission for that bit is cancelled.
- R9: With acknowledge checking disabled, `ack_sample` neither raises `halt_req` nor sets the flag, whatever the value of `rx_ack`.
- R10: With checking enabled, `ack_sample` loads `rx_ack` into the flag. If `rx_ack` is 1, `halt_req` is high for exactly the one cycle after the sampling edge.
- R11: Writing 0 to the acknowledge-check enable clears the not-acknowledge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select from the address decoder |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| arb_lost | input | 1 | Arbitration-loss strobe from the bus engine |
| slv_match | input | 1 | Strobe marking the first matching slave address frame |
| rx_rw | input | 1 | Received R/W bit, valid with `slv_match` |
| ack_sample | input | 1 | Acknowledge-sample strobe |
| rx_ack | input | 1 | Received acknowledge bit, valid with `ack_sample` |
| is_master | output | 1 | Current master-mode bit |
| is_tx | output | 1 | Current transmit-direction bit |
| ack_flag | output | 1 | Not-acknowledge flag |
| halt_req | output | 1 | One-cycle request to halt continuous transfer |

## Verification
Two functions can collide in one cycle: a software write and a hardware event on the same bit. The bench provokes this in two ways. It drives `arb_lost` in the same cycle as a write that sets master and transmit. It also drives `slv_match` with `rx_rw`=1 in the same cycle as a write of 0 to transmit, after a read has already granted permission. In both cases the bench checks that the hardware value is stored. It then checks that a further undo write without a fresh read is ignored, which shows that the collision re-locked the bit and cancelled the earlier permission.

// File: rtl/i2c_mcr_pkg.sv
package i2c_mcr_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned POS_MASTER = 5;
    localparam int unsigned POS_XMIT   = 4;
    localparam int unsigned POS_ACKCHK = 3;
    localparam int unsigned POS_NACK   = 1;
    localparam int unsigned NCELL      = 2;

    // state of one hardware-lockable bit
    typedef struct packed {
        logic val;
        logic lock;   // hardware changed the bit, undo not yet permitted
        logic armed;  // a read observed the locked value
    } cell_t;

    typedef struct packed {
        logic en;
        logic flag;
        logic halt;
    } ack_t;
endpackage

// File: rtl/mcr_sticky_bit.sv
module mcr_sticky_bit
    import i2c_mcr_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic hw_val,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic sw_rd,
    output logic bit_o
);
    cell_t st_d, st_q;
    logic  undo_ok;

    always_comb begin
        st_d    = st_q;
        undo_ok = sw_wr && (sw_val != st_q.val) && (!st_q.lock || st_q.armed);
        if (hw_evt) begin
            st_d.val   = hw_val;
            st_d.lock  = 1'b1;
            st_d.armed = 1'b0;
        end else if (undo_ok) begin
            st_d.val   = sw_val;
            st_d.lock  = 1'b0;
            st_d.armed = 1'b0;
        end else if (sw_rd && st_q.lock) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{val: RST_VAL, lock: 1'b0, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.val;
endmodule

// File: rtl/mcr_ack_unit.sv
module mcr_ack_unit
    import i2c_mcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic ack_sample,
    input  logic rx_ack,
    output logic en_o,
    output logic flag_o,
    output logic halt_o
);
    ack_t ak_d, ak_q;

    always_comb begin
        ak_d      = ak_q;
        ak_d.halt = 1'b0;
        if (en_wr) begin
            ak_d.en = en_val;
        end
        if (ack_sample && ak_q.en) begin
            ak_d.flag = rx_ack;
            ak_d.halt = rx_ack;
        end
        if (en_wr && !en_val) begin
            ak_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ak_q <= '0;
        end else begin
            ak_q <= ak_d;
        end
    end

    assign en_o   = ak_q.en;
    assign flag_o = ak_q.flag;
    assign halt_o = ak_q.halt;
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
    import i2c_mcr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             arb_lost,
    input  logic             slv_match,
    input  logic             rx_rw,
    input  logic             ack_sample,
    input  logic             rx_ack,
    output logic             is_master,
    output logic             is_tx,
    output logic             ack_flag,
    output logic             halt_req
);
    localparam int unsigned CELL_POS [NCELL] = '{POS_MASTER, POS_XMIT};

    logic             acc_wr, acc_rd;
    logic             arb_hit, slv_hit;
    logic [NCELL-1:0] evt, evt_val, cell_bits;
    logic             chk_en;
    logic             unused_wbits;

    always_comb begin
        acc_wr     = reg_sel && reg_wr;
        acc_rd     = reg_sel && reg_rd;
        arb_hit    = arb_lost && is_master;
        slv_hit    = slv_match && rx_rw && !is_master;
        evt[0]     = arb_hit;
        evt_val[0] = 1'b0;
        evt[1]     = arb_hit || slv_hit;
        evt_val[1] = slv_hit;
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        mcr_sticky_bit #(.RST_VAL(1'b0)) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_evt (evt[g]),
            .hw_val (evt_val[g]),
            .sw_wr  (acc_wr),
            .sw_val (reg_wdata[CELL_POS[g]]),
            .sw_rd  (acc_rd),
            .bit_o  (cell_bits[g])
        );
    end

    mcr_ack_unit u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_wr      (acc_wr),
        .en_val     (reg_wdata[POS_ACKCHK]),
        .ack_sample (ack_sample),
        .rx_ack     (rx_ack),
        .en_o       (chk_en),
        .flag_o     (ack_flag),
        .halt_o     (halt_req)
    );

    assign is_master    = cell_bits[0];
    assign is_tx        = cell_bits[1];
    assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[2:0]};

    always_comb begin
        reg_rdata = '0;
        if (acc_rd) begin
            reg_rdata[POS_MASTER] = is_master;
            reg_rdata[POS_XMIT]   = is_tx;
            reg_rdata[POS_ACKCHK] = chk_en;
            reg_rdata[POS_NACK]   = ack_flag;
        end
    end
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk
    import i2c_mcr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic             arb_lost,
    input logic             slv_match,
    input logic             rx_rw,
    input logic             ack_sample,
    input logic             rx_ack,
    input logic             is_master,
    input logic             is_tx,
    input logic             halt_req,
    input logic             chk_en
);
    a_r3_arb_clears_both: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && is_master) |=> (!is_master && !is_tx));

    a_r5_slave_sets_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_match && rx_rw && !is_master) |=> is_tx);

    a_r4_master_rises_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_master) |-> $past(reg_sel && reg_wr && reg_wdata[POS_MASTER]));

    a_r9_no_halt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_sample && !chk_en) |=> !halt_req);

    a_r10_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(ack_sample && rx_ack && chk_en));

    a_r6_tx_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_tx) |-> $past((arb_lost && is_master) ||
                               (reg_sel && reg_wr && !reg_wdata[POS_XMIT])));
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk u_mcr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .arb_lost   (arb_lost),
    .slv_match  (slv_match),
    .rx_rw      (rx_rw),
    .ack_sample (ack_sample),
    .rx_ack     (rx_ack),
    .is_master  (is_master),
    .is_tx      (is_tx),
    .halt_req   (halt_req),
    .chk_en     (chk_en)
);

// File: tb/test_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module test_i2c_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       arb_lost = 0, slv_match = 0, rx_rw = 0, ack_sample = 0, rx_ack = 0;
    logic       is_master, is_tx, ack_flag, halt_req;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    i2c_mode_ctrl i_i2c_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arb_lost(arb_lost),
        .slv_match(slv_match), .rx_rw(rx_rw), .ack_sample(ack_sample), .rx_ack(rx_ack),
        .is_master(is_master), .is_tx(is_tx), .ack_flag(ack_flag), .halt_req(halt_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v, input logic sel = 1'b1);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] exp);
        reg_sel = 1; reg_rd = 1;
        #1 chk(req, reg_rdata, exp);
        @(negedge clk);
        reg_sel = 0; reg_rd = 0;
    endtask

    task automatic st_chk(input string req, input logic m, input logic t);
        chk(req, {is_master, is_tx}, {m, t});
    endtask

    task automatic arb_pulse();
        arb_lost = 1; @(negedge clk); arb_lost = 0;
    endtask

    task automatic slv_pulse(input logic rw);
        slv_match = 1; rx_rw = rw; @(negedge clk); slv_match = 0; rx_rw = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {is_master, is_tx, ack_flag, halt_req}, 0);
        rd_chk("R1 read", 8'h00);
        chk("R2 idle rdata", reg_rdata, 0);
        // R2 layout
        wr(8'hFF);
        st_chk("R2 write sets", 1, 1);
        rd_chk("R2 read layout", 8'h38);
        wr(8'h00, 1'b0);
        rd_chk("R2 unselected write", 8'h38);
        // R3 arbitration loss
        arb_pulse();
        st_chk("R3 arb clear", 0, 0);
        // R4 / R7 lock until read
        wr(8'h38);
        st_chk("R4 R7 write before read ignored", 0, 0);
        rd_chk("R4 read locked", 8'h08);
        wr(8'h38);
        st_chk("R4 R7 write after read", 1, 1);
        // R3 no effect as slave
        wr(8'h08);
        st_chk("R4 unlocked plain write", 0, 0);
        arb_pulse();
        wr(8'h18);
        arb_pulse();
        st_chk("R3 arb ignored as slave", 0, 1);
        // R5 / R6
        wr(8'h08);
        slv_pulse(1'b0);
        st_chk("R5 rw=0 no set", 0, 0);
        slv_pulse(1'b1);
        st_chk("R5 rw=1 set", 0, 1);
        wr(8'h08);
        st_chk("R6 clear before read ignored", 0, 1);
        rd_chk("R6 read locked", 8'h18);
        wr(8'h08);
        st_chk("R6 clear after read", 0, 0);
        wr(8'h18);
        wr(8'h08);
        st_chk("R6 plain after consume", 0, 0);
        wr(8'h28);
        slv_pulse(1'b1);
        st_chk("R5 ignored in master", 1, 0);
        // R8 collisions
        reg_sel = 1; reg_wr = 1; reg_wdata = 8'h38; arb_lost = 1;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; arb_lost = 0;
        st_chk("R8 arb beats write", 0, 0);
        rd_chk("R8 read arms", 8'h08);
        reg_sel = 1; reg_wr = 1; reg_wdata = 8'h08; slv_match = 1; rx_rw = 1;
        @(negedge clk);
        reg_sel = 0; reg_wr = 0; slv_match = 0; rx_rw = 0;
        st_chk("R8 slave event beats write", 0, 1);
        wr(8'h08);
        st_chk("R8 arm cancelled", 0, 1);
        rd_chk("R8 rearm read", 8'h18);
        wr(8'h28);
        st_chk("R8 R4 unlock both", 1, 0);
        // R9 / R10 sweep
        for (int en = 0; en < 2; en++) begin
            for (int ra = 0; ra < 2; ra++) begin
                wr(8'h20 | (8'(en) << 3));
                ack_sample = 1; rx_ack = ra[0];
                @(negedge clk);
                ack_sample = 0; rx_ack = 0;
                chk(en ? "R10 halt" : "R9 halt", halt_req, en & ra);
                chk(en ? "R10 flag" : "R9 flag", ack_flag, en & ra);
                rd_chk(en ? "R10 read" : "R9 read",
                       8'h20 | (8'(en) << 3) | (8'(en & ra) << 1));
                chk("R10 pulse width", halt_req, 0);
            end
        end
        // R11
        wr(8'h20);
        chk("R11 flag cleared", ack_flag, 0);
        rd_chk("R11 read", 8'h20);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule